// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns the 6-bit operand specifier of a 16-bit instruction into everything the datapath needs to reach that operand. It produces the addressing mode, the register involved, the access width, and whether the operand consumes the extension word that follows the opcode. For memory operands it also computes the effective address. For the auto-increment and stack forms it computes the new value of the base register and raises a write enable for it.

The caller presents the specifier together with the current value of the relevant register, the extension word and a read/write flag. The block does not fetch instructions, touch memory or own the register file. Register R15, when used through plain indirection, behaves as a stack pointer: reads use the pointer and then bump it by two, and writes pre-decrement it. Specifiers 0x27 and 0x2F take the direct form, so post-increment never reaches R15.

Requests enter on a valid/ready handshake and leave through a single register stage on a second valid/ready handshake. The stage accepts a new request whenever it is empty or its current result is being taken in the same cycle. A result that is not taken stays unchanged.

Top module: `opd_mode_decoder`

## Requirements
- R1: When spec[5:4] is 0, mode code is 0 (register), out_reg_idx is spec[3:0], width is word (out_byte 0), and ea, writeback data, writeback enable and extension use are all 0.
- R2: Specifier 0x1F gives mode code 1 (immediate) with out_ext_used 1, out_reg_idx 0, out_byte 0, ea 0 and no writeback.
- R3: A specifier with (spec & 0x37) == 0x27 and not covered by R1/R2 gives mode code 2 (direct): ea equals the extension word, out_ext_used 1, out_byte equals spec[3], out_reg_idx 0, no writeback.
- R4: In the base-register modes (codes 3, 4, 5), out_byte equals spec[3] (1 = byte, 0 = word) and out_reg_idx is {1, spec[2:0]}, i.e. R8 to R15.
- R5: spec[5:4] = 1 with a base other than R15 gives mode code 3 (indirect): ea equals the register value, no writeback, no extension use.
- R6: spec[5:4] = 2 (not direct) gives mode code 4 (post-increment): ea equals the register value, writeback enable 1, and writeback data equals the register value plus 1 for byte or plus 2 for word, modulo 2^16.
- R7: spec[5:4] = 3 gives mode code 5 (indexed): ea equals register value plus extension word modulo 2^16, out_ext_used 1, no writeback.
- R8: Specifier 0x17 (indirect through R15, mode code 3) on a read gives ea equal to the register value and writeback data equal to that value plus 2. On a write, both ea and writeback data equal the register value minus 2. Both cases have writeback enable 1, and all arithmetic wraps modulo 2^16.
- R9: Specifier 0x3F (byte access based on R15) raises out_illegal. No other specifier raises it, and out_illegal forces writeback enable and data to 0.
- R10: in_wr has no effect on any output for every specifier except 0x17.
- R11: in_ready is high when the output stage is empty or out_ready is high. An accepted request appears with out_valid high after one clock. A result held with out_ready low stays stable.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_spec | input | 6 | Operand specifier |
| in_reg | input | 16 | Value of the selected register |
| in_ext | input | 16 | Extension word following the opcode |
| in_wr | input | 1 | 1 = operand is a destination (write) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mode | output | 3 | Mode code (0 reg, 1 imm, 2 direct, 3 indirect, 4 post-inc, 5 indexed) |
| out_reg_idx | output | 4 | Register number used |
| out_byte | output | 1 | 1 = byte access, 0 = word |
| out_ea | output | 16 | Effective address |
| out_wb_data | output | 16 | New base register value |
| out_wb_en | output | 1 | Write out_wb_data to out_reg_idx |
| out_ext_used | output | 1 | Extension word consumed |
| out_illegal | output | 1 | Forbidden specifier |

## Verification
The bench sweeps all 64 specifiers in both read and write sense, using register and extension values chosen to force wrap-around. It goes after the priority between register, immediate, direct and base-register forms. A wrong order would make 0x1F look like a byte access through R15, or make 0x27 look like a post-increment. The stack form is checked at a pointer of zero: a design that forgets the pre-decrement on writes, or that decrements on reads, shows the wrong address or writeback. A back-pressure episode checks that a stalled result does not change and that the waiting request enters exactly when the result leaves.

// File: rtl/opd_pkg.sv
package opd_pkg;

  typedef enum logic [2:0] {
    MODE_REG  = 3'd0,
    MODE_IMM  = 3'd1,
    MODE_DIR  = 3'd2,
    MODE_IND  = 3'd3,
    MODE_PINC = 3'd4,
    MODE_IDX  = 3'd5
  } opd_mode_e;

  localparam int SPEC_BITS = 6;
  localparam int IDX_BITS  = 4;

  localparam logic [SPEC_BITS-1:0] SPEC_IMM   = 6'h1F;
  localparam logic [SPEC_BITS-1:0] DIR_MASK   = 6'h37;
  localparam logic [SPEC_BITS-1:0] DIR_MATCH  = 6'h27;

  typedef struct packed {
    opd_mode_e             mode;
    logic [IDX_BITS-1:0]   idx;
    logic                  byte_w;
    logic                  ext_use;
    logic                  on_stack;
    logic                  illegal;
  } opd_dec_t;

endpackage

// File: rtl/opd_spec_decode.sv
module opd_spec_decode
  import opd_pkg::*;
#(
  parameter int          SPEC_W = SPEC_BITS,
  parameter logic [3:0]  SP_IDX = 4'd15
) (
  input  logic [SPEC_W-1:0] spec,
  output opd_dec_t          dec
);

  localparam int TOP_HI = SPEC_W - 1;
  localparam int TOP_LO = SPEC_W - 2;

  logic [1:0]          top;
  logic [IDX_BITS-1:0] base;

  assign top  = spec[TOP_HI:TOP_LO];
  assign base = {1'b1, spec[2:0]};

  always_comb begin
    dec = '0;
    dec.mode = MODE_REG;
    if (top == 2'd0) begin
      dec.mode = MODE_REG;
      dec.idx  = spec[3:0];
    end else if (spec == SPEC_IMM) begin
      dec.mode    = MODE_IMM;
      dec.ext_use = 1'b1;
    end else if ((spec & DIR_MASK) == DIR_MATCH) begin
      dec.mode    = MODE_DIR;
      dec.byte_w  = spec[3];
      dec.ext_use = 1'b1;
    end else begin
      dec.idx    = base;
      dec.byte_w = spec[3];
      case (top)
        2'd1:    dec.mode = MODE_IND;
        2'd2:    dec.mode = MODE_PINC;
        default: begin
          dec.mode    = MODE_IDX;
          dec.ext_use = 1'b1;
        end
      endcase
      dec.on_stack = (base == SP_IDX) && (top == 2'd1);
      dec.illegal  = (base == SP_IDX) && (spec[3] || top == 2'd2);
    end
  end

endmodule

// File: rtl/opd_addr_gen.sv
module opd_addr_gen
  import opd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  opd_dec_t          dec,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] ext_val,
  input  logic              is_wr,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] wb_data,
  output logic              wb_en
);

  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(2);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sp_dec;
  logic [ADDR_W-1:0] sp_inc;
  logic [ADDR_W-1:0] ea_raw;
  logic [ADDR_W-1:0] wb_raw;
  logic              wb_raw_en;

  assign step   = dec.byte_w ? STEP_B : STEP_W;
  assign sp_dec = reg_val - STEP_W;
  assign sp_inc = reg_val + STEP_W;

  always_comb begin
    ea_raw    = '0;
    wb_raw    = '0;
    wb_raw_en = 1'b0;
    case (dec.mode)
      MODE_DIR: ea_raw = ext_val;
      MODE_IND: begin
        if (dec.on_stack) begin
          wb_raw_en = 1'b1;
          if (is_wr) begin
            ea_raw = sp_dec;
            wb_raw = sp_dec;
          end else begin
            ea_raw = reg_val;
            wb_raw = sp_inc;
          end
        end else begin
          ea_raw = reg_val;
        end
      end
      MODE_PINC: begin
        ea_raw    = reg_val;
        wb_raw    = reg_val + step;
        wb_raw_en = 1'b1;
      end
      MODE_IDX: ea_raw = reg_val + ext_val;
      default: ;
    endcase
  end

  assign ea      = ea_raw;
  assign wb_en   = wb_raw_en & ~dec.illegal;
  assign wb_data = dec.illegal ? '0 : wb_raw;

endmodule

// File: rtl/opd_out_stage.sv
module opd_out_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data
);

  logic             vld_q;
  logic [PAY_W-1:0] data_q;

  assign in_ready  = ~vld_q | out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (in_valid && in_ready) data_q <= in_data;
    end
  end

endmodule

// File: rtl/opd_mode_decoder.sv
module opd_mode_decoder
  import opd_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         SPEC_W = 6,
  parameter logic [3:0] SP_IDX = 4'd15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SPEC_W-1:0] in_spec,
  input  logic [ADDR_W-1:0] in_reg,
  input  logic [ADDR_W-1:0] in_ext,
  input  logic              in_wr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_mode,
  output logic [3:0]        out_reg_idx,
  output logic              out_byte,
  output logic [ADDR_W-1:0] out_ea,
  output logic [ADDR_W-1:0] out_wb_data,
  output logic              out_wb_en,
  output logic              out_ext_used,
  output logic              out_illegal
);

  localparam int PAY_W = 3 + IDX_BITS + 1 + ADDR_W + ADDR_W + 3;

  opd_dec_t          dec;
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] wb_data;
  logic              wb_en;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  opd_spec_decode #(.SPEC_W(SPEC_W), .SP_IDX(SP_IDX)) u_dec (
    .spec (in_spec),
    .dec  (dec)
  );

  opd_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .dec     (dec),
    .reg_val (in_reg),
    .ext_val (in_ext),
    .is_wr   (in_wr),
    .ea      (ea),
    .wb_data (wb_data),
    .wb_en   (wb_en)
  );

  assign pay_in = {dec.mode, dec.idx, dec.byte_w, ea, wb_data,
                   wb_en, dec.ext_use, dec.illegal};

  opd_out_stage #(.PAY_W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_mode, out_reg_idx, out_byte, out_ea, out_wb_data,
          out_wb_en, out_ext_used, out_illegal} = pay_out;

  // R9: a forbidden specifier never writes a register
  p_ill_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wb_en);

  // R11: an accepted request is visible one clock later
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R11: a stalled result holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea)
      && $stable(out_mode) && $stable(out_wb_data) && $stable(out_reg_idx));

  // R6: post-increment writes back address plus access size
  p_pinc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == 3'(MODE_PINC) |->
      out_wb_en && out_wb_data == ADDR_W'(out_ea + (out_byte ? 1 : 2)));

  // R8: stack form only through the stack register, moving by two or equal
  p_stack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == 3'(MODE_IND) && out_wb_en |->
      out_reg_idx == SP_IDX &&
      (out_wb_data == out_ea || out_wb_data == ADDR_W'(out_ea + 2)));

  // R1: register operands use no extension word and no writeback
  p_reg_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == 3'(MODE_REG) |-> !out_ext_used && !out_wb_en);

endmodule

// File: tb/opd_mode_decoder_tb.sv
`timescale 1ns/1ps
module opd_mode_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_spec = '0;
  logic [15:0] in_reg = '0;
  logic [15:0] in_ext = '0;
  logic        in_wr = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_mode;
  logic [3:0]  out_reg_idx;
  logic        out_byte;
  logic [15:0] out_ea;
  logic [15:0] out_wb_data;
  logic        out_wb_en;
  logic        out_ext_used;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  opd_mode_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_spec(in_spec), .in_reg(in_reg), .in_ext(in_ext), .in_wr(in_wr),
    .out_valid(out_valid), .out_ready(out_ready), .out_mode(out_mode),
    .out_reg_idx(out_reg_idx), .out_byte(out_byte), .out_ea(out_ea),
    .out_wb_data(out_wb_data), .out_wb_en(out_wb_en),
    .out_ext_used(out_ext_used), .out_illegal(out_illegal)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [3:0]  idx;
    logic        byt;
    logic [15:0] ea;
    logic [15:0] wbd;
    logic        wbe;
    logic        ext;
    logic        ill;
  } exp_t;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] s);
    if (s[5:4] == 2'd0) return "R1";
    if (s == 6'h1F) return "R2";
    if ((s & 6'h37) == 6'h27) return "R3";
    if (s == 6'h17) return "R8";
    if (s[5:4] == 2'd1) return "R5";
    if (s[5:4] == 2'd2) return "R6";
    return "R7";
  endfunction

  function automatic exp_t model(input logic [5:0] s, input logic [15:0] r,
                                 input logic [15:0] x, input logic w);
    exp_t e;
    e = '0;
    if (s[5:4] == 2'd0) begin
      e.mode = 3'd0; e.idx = s[3:0];
    end else if (s == 6'h1F) begin
      e.mode = 3'd1; e.ext = 1'b1;
    end else if ((s & 6'h37) == 6'h27) begin
      e.mode = 3'd2; e.ea = x; e.ext = 1'b1; e.byt = s[3];
    end else begin
      e.idx = {1'b1, s[2:0]};
      e.byt = s[3];
      if (s[5:4] == 2'd1) begin
        e.mode = 3'd3;
        if (s == 6'h17) begin
          e.wbe = 1'b1;
          if (w) begin e.ea = r - 16'd2; e.wbd = r - 16'd2; end
          else   begin e.ea = r;         e.wbd = r + 16'd2; end
        end else e.ea = r;
      end else if (s[5:4] == 2'd2) begin
        e.mode = 3'd4; e.ea = r; e.wbe = 1'b1;
        e.wbd = r + (s[3] ? 16'd1 : 16'd2);
      end else begin
        e.mode = 3'd5; e.ea = r + x; e.ext = 1'b1;
        e.ill = (s == 6'h3F);
      end
    end
    return e;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [15:0] regs_v [3];
    logic [15:0] exts_v [3];
    regs_v[0] = 16'h1234; exts_v[0] = 16'h0102;
    regs_v[1] = 16'hFFFF; exts_v[1] = 16'h0003;
    regs_v[2] = 16'h0000; exts_v[2] = 16'hFFFE;

    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "out_valid", out_valid, 0);
    chk("R12", "in_ready", in_ready, 1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "out_valid after reset", out_valid, 0);

    for (int v = 0; v < 3; v++) begin
      for (int sp = 0; sp < 64; sp++) begin
        for (int w = 0; w < 2; w++) begin
          exp_t e;
          string t;
          string tb;
          @(negedge clk);
          in_spec = 6'(sp); in_reg = regs_v[v]; in_ext = exts_v[v];
          in_wr = w[0]; in_valid = 1'b1;
          e = model(6'(sp), regs_v[v], exts_v[v], w[0]);
          t = tag_of(6'(sp));
          tb = (e.mode >= 3'd3) ? "R4" : t;
          @(negedge clk);
          in_valid = 1'b0;
          chk("R11", "out_valid", out_valid, 1);
          chk(t,  "mode", out_mode, e.mode);
          chk(tb, "reg_idx", out_reg_idx, e.idx);
          chk(tb, "byte", out_byte, e.byt);
          chk(t,  "ea", out_ea, e.ea);
          chk(t,  "wb_data", out_wb_data, e.wbd);
          chk(t,  "wb_en", out_wb_en, e.wbe);
          chk(t,  "ext_used", out_ext_used, e.ext);
          chk("R9", "illegal", out_illegal, e.ill);
          if (w == 1 && sp != 'h17) begin
            exp_t e0;
            e0 = model(6'(sp), regs_v[v], exts_v[v], 1'b0);
            // R10: write sense matches read-sense result
            chk("R10", "ea vs read", out_ea, e0.ea);
            chk("R10", "wb vs read", out_wb_data, e0.wbd);
          end
        end
      end
    end

    // R11: back-pressure episode
    @(negedge clk);
    out_ready = 1'b0;
    in_spec = 6'h21; in_reg = 16'h0010; in_ext = 16'h0; in_wr = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_spec = 6'h33; in_reg = 16'h1000; in_ext = 16'h0020;
    chk("R11", "in_ready while full", in_ready, 0);
    chk("R11", "first ea", out_ea, 16'h0010);
    repeat (3) @(negedge clk);
    chk("R11", "held valid", out_valid, 1);
    chk("R11", "held ea", out_ea, 16'h0010);
    chk("R11", "held wb", out_wb_data, 16'h0012);
    chk("R11", "held mode", out_mode, 4);
    out_ready = 1'b1;
    #0.5;
    chk("R11", "in_ready when drained", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "second valid", out_valid, 1);
    chk("R11", "second ea", out_ea, 16'h1020);
    chk("R11", "second mode", out_mode, 5);
    @(negedge clk);
    chk("R11", "empty after drain", out_valid, 0);

    finish_run();
  end

endmodule